// File: doc/BRIEF.md
# Erasable Sector Storage Model

This block is a synthesizable, scaled-down model of one flash storage device built from equal sectors. A host reads a word, programs a word, or erases a chosen set of sectors in a single command. Programming can only pull bits from one to zero, so each stored word becomes the AND of its old value and the written value. The only way to bring bits back to one is to erase the whole sector that holds them.

An erase is selected by a bitmask with one bit per sector. Any number of sectors can be picked at once, including a pair. The erase controller works on the selected sectors one after another, lowest index first, and spends `ERASE_CYC` cycles on each. While it runs, `busy` is high. Reads of any sector named in the running command return all ones. Program commands that arrive during that time are dropped and flagged on `err`.

Addresses are split into two fields. The upper `log2(SECTORS)` bits give the sector index, and the lower `log2(SECT_WORDS)` bits give the word within that sector. Bit `s` of `sect_mask` selects sector `s`. Both sizes must be powers of two.

The erase controller has two named states. `ERS_IDLE` leaves it on `start`, which is an accepted erase command, and goes to `ERS_WIPE`. `ERS_WIPE` counts `ERASE_CYC` cycles for the current sector, clears that sector on the last cycle and moves to the next selected one. It returns to `ERS_IDLE` on the last cycle of the final sector.

Top module: `flash_sector_model`

## Requirements
- R1: After reset, `busy`, `err` and `rdata` are zero and every location reads as all ones.
- R2: A cycle with `rd_en` high loads `rdata` at that clock edge with the word at `addr`. `rdata` keeps its value while `rd_en` is low.
- R3: A program accepted while idle leaves the word equal to the old word AND `wdata`. A read in the same cycle returns the old word.
- R4: Programming ones onto zero bits leaves those bits at zero. Only an erase restores them.
- R5: An erase sets every word of each sector whose mask bit is 1 to all ones and leaves all other sectors unchanged.
- R6: An erase with a nonzero mask accepted while idle raises `busy` at the next edge. `busy` stays high for exactly `ERASE_CYC` times the number of set mask bits.
- R7: While `busy` is high, a read of a sector selected by the running erase returns all ones. A read of any other sector returns its stored word.
- R8: A program issued while `busy` is high changes no word. `err` is high in the cycle after it. `err` is low after any cycle without such a program.
- R9: An erase command issued while `busy`, or with an all-zero mask, is ignored. `busy` does not rise and no sector changes.
- R10: A program issued in the same cycle as an accepted erase is dropped without raising `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| pgm_en | input | 1 | Program strobe |
| ers_en | input | 1 | Sector erase strobe |
| addr | input | ADDR_W | Word address, sector index in the upper bits |
| wdata | input | DATA_W | Program data |
| sect_mask | input | SECTORS | Sector selection for erase, bit s picks sector s |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High while an erase runs |
| err | output | 1 | Pulses the cycle after a program rejected while busy |

## Verification
Read data and `err` are due one edge after their strobe. `busy` rises one edge after an accepted erase and falls `ERASE_CYC` times the number of selected sectors later. The bench drives every input on a falling edge and samples on the next falling edge, which falls between the edge that takes the stimulus and the following one. It counts `busy` at each falling edge until `busy` drops, and that count must match the expected erase length. A reference array inside the bench is updated only when a command has no further effect pending, so each read-back compares against the state the requirements predict.

// File: rtl/flash_pkg.sv
package flash_pkg;
    typedef enum logic [0:0] {
        ERS_IDLE = 1'b0,
        ERS_WIPE = 1'b1
    } ers_state_t;
endpackage

// File: rtl/flash_lowest_set.sv
module flash_lowest_set #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int SECTORS    = 16,
    parameter int SECT_WORDS = 16,
    parameter int DATA_W     = 8,
    localparam int WORDS  = SECTORS * SECT_WORDS,
    localparam int SECT_W = $clog2(SECTORS),
    localparam int OFF_W  = $clog2(SECT_WORDS),
    localparam int ADDR_W = SECT_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_we,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              wipe_en,
    input  logic [SECT_W-1:0] wipe_sect,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) begin
                cells[i] <= '1;
            end else if (wipe_en && (SECT_W'(i / SECT_WORDS) == wipe_sect)) begin
                cells[i] <= '1;
            end else if (pgm_we && (pgm_addr == ADDR_W'(i))) begin
                cells[i] <= cells[i] & pgm_data;
            end
        end
    end

    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_pkg::*;
#(
    parameter int SECTORS   = 16,
    parameter int ERASE_CYC = 4,
    localparam int SECT_W = $clog2(SECTORS),
    localparam int CNT_W  = $clog2(ERASE_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SECTORS-1:0] start_mask,
    output logic               busy,
    output logic               wipe_en,
    output logic [SECT_W-1:0]  wipe_sect,
    output logic [SECTORS-1:0] held_mask
);
    ers_state_t         state, state_nx;
    logic [SECTORS-1:0] pending;
    logic [SECTORS-1:0] pending_left;
    logic [CNT_W-1:0]   tick;
    logic [SECT_W-1:0]  cur;
    logic               cur_found;
    logic               last_tick;

    flash_lowest_set #(.N(SECTORS)) u_pick (
        .vec   (pending),
        .idx   (cur),
        .found (cur_found)
    );

    assign last_tick    = (tick == CNT_W'(ERASE_CYC - 1)) && cur_found;
    assign pending_left = pending & ~(SECTORS'(1) << cur);

    always_comb begin
        state_nx = state;
        unique case (state)
            ERS_IDLE: if (start) state_nx = ERS_WIPE;
            ERS_WIPE: if (last_tick && (pending_left == '0)) state_nx = ERS_IDLE;
            default:  state_nx = ERS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ERS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= '0;
            held_mask <= '0;
            tick      <= '0;
        end else begin
            unique case (state)
                ERS_IDLE: begin
                    tick <= '0;
                    if (start) begin
                        pending   <= start_mask;
                        held_mask <= start_mask;
                    end
                end
                ERS_WIPE: begin
                    if (last_tick) begin
                        tick    <= '0;
                        pending <= pending_left;
                    end else begin
                        tick <= tick + CNT_W'(1);
                    end
                end
                default: tick <= '0;
            endcase
        end
    end

    always_comb begin
        busy      = (state == ERS_WIPE);
        wipe_en   = (state == ERS_WIPE) && last_tick;
        wipe_sect = cur;
    end
endmodule

// File: rtl/flash_sector_model.sv
module flash_sector_model #(
    parameter int SECTORS    = 16,
    parameter int SECT_WORDS = 16,
    parameter int DATA_W     = 8,
    parameter int ERASE_CYC  = 4,
    localparam int SECT_W = $clog2(SECTORS),
    localparam int OFF_W  = $clog2(SECT_WORDS),
    localparam int ADDR_W = SECT_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               pgm_en,
    input  logic               ers_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [SECTORS-1:0] sect_mask,
    output logic [DATA_W-1:0]  rdata,
    output logic               busy,
    output logic               err
);
    logic               ers_accept;
    logic               pgm_accept;
    logic               wipe_en;
    logic [SECT_W-1:0]  wipe_sect;
    logic [SECTORS-1:0] held_mask;
    logic [DATA_W-1:0]  rd_word;
    logic [SECT_W-1:0]  rd_sect;

    assign ers_accept = ers_en && !busy && (sect_mask != '0);
    assign pgm_accept = pgm_en && !busy && !ers_accept;
    assign rd_sect    = addr[ADDR_W-1:OFF_W];

    flash_erase_ctrl #(
        .SECTORS   (SECTORS),
        .ERASE_CYC (ERASE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ers_accept),
        .start_mask (sect_mask),
        .busy       (busy),
        .wipe_en    (wipe_en),
        .wipe_sect  (wipe_sect),
        .held_mask  (held_mask)
    );

    flash_array #(
        .SECTORS    (SECTORS),
        .SECT_WORDS (SECT_WORDS),
        .DATA_W     (DATA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .pgm_we    (pgm_accept),
        .pgm_addr  (addr),
        .pgm_data  (wdata),
        .wipe_en   (wipe_en),
        .wipe_sect (wipe_sect),
        .rd_addr   (addr),
        .rd_word   (rd_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= pgm_en && busy;
            if (rd_en) begin
                if (busy && held_mask[rd_sect]) rdata <= '1;
                else                            rdata <= rd_word;
            end
        end
    end
endmodule

// File: rtl/flash_sector_model_chk.sv
module flash_sector_model_chk #(
    parameter int SECTORS   = 16,
    parameter int ERASE_CYC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ers_en,
    input logic               pgm_en,
    input logic [SECTORS-1:0] sect_mask,
    input logic               busy,
    input logic               err
);
    int unsigned run;

    always_ff @(posedge clk) begin
        if (!rst_n)    run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    p_erase_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ers_en && (sect_mask != '0)) |=> busy);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ((run != 0) && ((run % ERASE_CYC) == 0)));

    p_zero_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ers_en && (sect_mask == '0)) |=> !busy);

    p_err_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pgm_en) |=> err);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && pgm_en) |=> !err);
endmodule

bind flash_sector_model flash_sector_model_chk #(
    .SECTORS   (SECTORS),
    .ERASE_CYC (ERASE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ers_en    (ers_en),
    .pgm_en    (pgm_en),
    .sect_mask (sect_mask),
    .busy      (busy),
    .err       (err)
);

// File: tb/tb_flash_sector_model.sv
module tb_flash_sector_model;
    localparam int SECTORS = 16, SECT_WORDS = 16, DATA_W = 8, ERASE_CYC = 4;
    localparam int WORDS = SECTORS * SECT_WORDS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_en = 0, pgm_en = 0, ers_en = 0;
    logic [7:0] addr = '0, wdata = '0;
    logic [15:0] sect_mask = '0;
    logic [7:0] rdata;
    logic busy, err;

    int checks = 0, errors = 0;
    logic [7:0] exp_mem [WORDS];

    always #5 clk = ~clk;

    flash_sector_model #(.SECTORS(SECTORS), .SECT_WORDS(SECT_WORDS),
                         .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .pgm_en(pgm_en), .ers_en(ers_en),
        .addr(addr), .wdata(wdata), .sect_mask(sect_mask),
        .rdata(rdata), .busy(busy), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int erase_len(input logic [15:0] m);
        return ERASE_CYC * $countones(m);
    endfunction

    function automatic void model_erase(input logic [15:0] m);
        for (int i = 0; i < WORDS; i++)
            if (m[i / SECT_WORDS]) exp_mem[i] = 8'hff;
    endfunction

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0;
        chk(rdata == exp_mem[a], tag, rdata, exp_mem[a]);
    endtask

    task automatic pgm(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); pgm_en = 1; addr = a; wdata = d;
        @(negedge clk); pgm_en = 0;
        chk(err == 1'b0, "R8 idle program no err", err, 0);
        exp_mem[a] = exp_mem[a] & d;
    endtask

    task automatic erase_cmd(input logic [15:0] m, input string tag);
        int n;
        @(negedge clk); ers_en = 1; sect_mask = m;
        @(negedge clk); ers_en = 0; sect_mask = '0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == erase_len(m), tag, n, erase_len(m));
        model_erase(m);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) exp_mem[i] = 8'hff;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(err == 0, "R1 err after reset", err, 0);
        chk(rdata == 0, "R1 rdata after reset", rdata, 0);
        rd(8'h00, "R1 erased read"); rd(8'hff, "R1 erased read");

        // R3 AND programming, same-cycle read sees old word
        pgm(8'h41, 8'hf0);
        @(negedge clk); pgm_en = 1; rd_en = 1; addr = 8'h41; wdata = 8'h3c;
        @(negedge clk); pgm_en = 0; rd_en = 0;
        chk(rdata == 8'hf0, "R3 same-cycle read old", rdata, 8'hf0);
        exp_mem[8'h41] = 8'h30;
        rd(8'h41, "R3 AND result");

        // R4 ones cannot restore zeros
        pgm(8'h40, 8'h0f); pgm(8'h40, 8'hff);
        rd(8'h40, "R4 no 0 to 1");

        // R2 hold while rd_en low
        held = rdata;
        @(negedge clk); addr = 8'h00;
        repeat (3) @(negedge clk);
        chk(rdata == held, "R2 rdata holds", rdata, held);

        // R5 single sector erase
        erase_cmd(16'h0010, "R6 busy length one sector");
        rd(8'h40, "R5 erased word"); rd(8'h41, "R5 erased word");

        // R7/R8/R9 interference during an erase of sectors 2 and 5
        pgm(8'h23, 8'h5a); pgm(8'h71, 8'h3c); pgm(8'h95, 8'h0f);
        @(negedge clk); ers_en = 1; sect_mask = 16'h0024;
        @(negedge clk); ers_en = 0; sect_mask = '0; n = 0;
        if (busy) n++;
        chk(busy == 1, "R6 busy rises", busy, 1);
        rd_en = 1; addr = 8'h23;
        @(negedge clk); if (busy) n++;
        chk(rdata == 8'hff, "R7 erasing sector reads ones", rdata, 8'hff);
        addr = 8'h71;
        @(negedge clk); if (busy) n++;
        chk(rdata == exp_mem[8'h71], "R7 other sector reads stored", rdata, exp_mem[8'h71]);
        rd_en = 0; pgm_en = 1; wdata = 8'h00; ers_en = 1; sect_mask = 16'h0200;
        @(negedge clk); if (busy) n++;
        chk(err == 1, "R8 err after busy program", err, 1);
        pgm_en = 0; ers_en = 0; sect_mask = '0;
        @(negedge clk); if (busy) n++;
        chk(err == 0, "R8 err one cycle", err, 0);
        @(negedge clk);
        while (busy) begin n++; @(negedge clk); end
        chk(n == erase_len(16'h0024), "R6 busy length two sectors", n, erase_len(16'h0024));
        model_erase(16'h0024);
        rd(8'h23, "R5 sector 2 erased");
        rd(8'h71, "R8 rejected program left word");
        rd(8'h95, "R9 erase while busy ignored");

        // R9 zero mask
        @(negedge clk); ers_en = 1; sect_mask = '0;
        @(negedge clk); ers_en = 0;
        chk(busy == 0, "R9 zero mask no busy", busy, 0);
        rd(8'h95, "R9 zero mask no change");

        // R10 program dropped when erase accepted same cycle
        @(negedge clk); ers_en = 1; sect_mask = 16'h0008; pgm_en = 1; addr = 8'h45; wdata = 8'h00;
        @(negedge clk); ers_en = 0; sect_mask = '0; pgm_en = 0; n = 0;
        chk(err == 0, "R10 no err", err, 0);
        while (busy) begin n++; @(negedge clk); end
        chk(n == erase_len(16'h0008), "R6 busy length", n, erase_len(16'h0008));
        model_erase(16'h0008);
        rd(8'h45, "R10 program dropped");

        // random mix
        for (int k = 0; k < 300; k++) begin
            int op;
            op = $urandom % 10;
            if (op < 5)      rd(8'($urandom), "R2 random read");
            else if (op < 9) pgm(8'($urandom), 8'($urandom));
            else             erase_cmd(16'($urandom & $urandom), "R6 random erase length");
        end
        for (int i = 0; i < WORDS; i++) rd(8'(i), "R5 final sweep");
        finish_run();
    end
endmodule